// File: doc/BRIEF.md
# Iterative Differential Equation Solver Datapath

This block integrates the second-order linear equation y'' + 3·z·y' + 3·y = 0 by stepping a fixed loop body in hardware. Each pass advances the independent variable by a step `dz` and updates the derivative `u` and the solution `y`. A pulse on `start` captures the initial `z`, `u`, `y`, the step and the upper bound. The block then repeats the loop body while `z` stays below the bound, and finally raises a one-cycle `done` with the results on `res_z`, `res_u` and `res_y`.

All values are signed 16-bit Q8.8 fixed point. The loop body is hand-scheduled onto a few multipliers, one adder, one subtractor and one comparator, with temporaries held in registers between control steps. The parameter `SHARED_MUL` picks one of two bindings of the same loop body. The parallel binding runs one pass in four control steps on three multipliers. The shared binding runs all six products through a single multiplier in seven steps.

Top module: `diffeq_solver`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are 0 and `res_z`, `res_u`, `res_y` are 0.
- R2: A `start` sampled while `busy` is 0 captures `init_z`, `init_u`, `init_y`, `step_dz` and `bound_a`, and `busy` is 1 from the next cycle on.
- R3: One pass computes zn = z + dz, yn = y + P(u,dz) and un = u − P(P(3,y),dz) − P(P(P(3,z),u),dz), then replaces z, u, y with zn, un, yn together. P(p,q) is the full 32-bit signed product shifted arithmetically right by 8 and cut to its low 16 bits, and 3 is the Q8.8 code 0x0300. Sums and differences wrap modulo 2^16.
- R4: Passes repeat while z < bound (signed compare). When `done` rises, the presented z is not below the bound.
- R5: With `SHARED_MUL`=0 each pass takes 4 cycles. `done` is high exactly 1 + 4·N clock edges after the start edge, where N is the number of passes.
- R6: With `SHARED_MUL`=1 each pass takes 7 cycles. `done` is high exactly 1 + 7·N edges after the start edge.
- R7: If init_z is not below bound_a, `done` rises one edge after the start edge, and the results equal init_z, init_u and init_y.
- R8: `done` is a single-cycle pulse, and `busy` is 0 in that cycle.
- R9: A `start` pulse, with any input values, while `busy` is 1 has no effect on the run in progress: the results and the cycle count are those of the original inputs.
- R10: After `done`, the results hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| init_z | input | 16 | Initial independent variable (Q8.8) |
| init_u | input | 16 | Initial derivative (Q8.8) |
| init_y | input | 16 | Initial solution value (Q8.8) |
| step_dz | input | 16 | Integration step (Q8.8) |
| bound_a | input | 16 | Upper bound on z (Q8.8) |
| res_z | output | 16 | Current/final z |
| res_u | output | 16 | Current/final u |
| res_y | output | 16 | Current/final y |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block side by side, one with `SHARED_MUL`=0 and one with `SHARED_MUL`=1. Both copies run the same directed and random stimulus. This brings both the four-step and the seven-step schedule, with their different operand multiplexing and temporary lifetimes, within reach of the same bit-exact reference loop and the same per-pass latency formula. The default 16-bit width with 8 fractional bits exercises truncation of negative products as well as wraparound of u and y over long runs.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CHK  = 2'd1,
      ST_RUN  = 2'd2
   } dq_state_e;

   function automatic int steps_for(input bit shared_mul);
      return shared_mul ? 7 : 4;
   endfunction
endpackage

// File: rtl/diffeq_qmul.sv
module diffeq_qmul #(
   parameter int W = 16,
   parameter int F = 8
) (
   input  logic signed [W-1:0] op_a,
   input  logic signed [W-1:0] op_b,
   output logic signed [W-1:0] prod
);
   logic signed [2*W-1:0] full;
   always_comb begin
      full = op_a * op_b;
      prod = full[F+W-1:F];
   end
endmodule

// File: rtl/diffeq_ctrl.sv
module diffeq_ctrl
   import diffeq_pkg::*;
#(
   parameter int STEPS  = 4,
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              lt,
   output logic              busy,
   output logic              done,
   output logic              load,
   output logic              chk,
   output logic              run,
   output logic              last,
   output logic [STEP_W-1:0] step
);
   dq_state_e        state_q;
   logic [STEP_W-1:0] cnt_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) state_q <= ST_CHK;
            ST_CHK: begin
               cnt_q <= '0;
               if (lt) state_q <= ST_RUN;
               else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_RUN: begin
               if (cnt_q == STEP_W'(STEPS - 1)) begin
                  cnt_q <= '0;
                  if (!lt) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy = (state_q != ST_IDLE);
      done = done_q;
      load = (state_q == ST_IDLE) && start;
      chk  = (state_q == ST_CHK);
      run  = (state_q == ST_RUN);
      last = run && (cnt_q == STEP_W'(STEPS - 1));
      step = cnt_q;
   end

   p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (int'(cnt_q) < STEPS));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
endmodule

// File: rtl/diffeq_datapath.sv
module diffeq_datapath #(
   parameter int W          = 16,
   parameter int F          = 8,
   parameter bit SHARED_MUL = 1'b0,
   parameter int STEP_W     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                chk,
   input  logic                run,
   input  logic                last,
   input  logic [STEP_W-1:0]   step,
   input  logic signed [W-1:0] in_z,
   input  logic signed [W-1:0] in_u,
   input  logic signed [W-1:0] in_y,
   input  logic signed [W-1:0] in_dz,
   input  logic signed [W-1:0] in_a,
   output logic                lt,
   output logic signed [W-1:0] out_z,
   output logic signed [W-1:0] out_u,
   output logic signed [W-1:0] out_y
);
   localparam logic signed [W-1:0] THREE = W'(3) <<< F;

   logic signed [W-1:0] z_q, u_q, y_q, dz_q, a_q;
   logic signed [W-1:0] m1_q, m2_q, m3_q, m4_q, m5_q, m6_q;
   logic signed [W-1:0] zn_q, yn_q, s1_q;
   logic signed [W-1:0] add_a, add_b, sub_a, sub_b, sum, diff, cmp_l;

   // shared adder, subtractor and comparator
   always_comb begin
      sum   = add_a + add_b;
      diff  = sub_a - sub_b;
      cmp_l = chk ? z_q : zn_q;
      lt    = (cmp_l < a_q);
   end

   // architectural registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z_q  <= '0;
         u_q  <= '0;
         y_q  <= '0;
         dz_q <= '0;
         a_q  <= '0;
      end else if (load) begin
         z_q  <= in_z;
         u_q  <= in_u;
         y_q  <= in_y;
         dz_q <= in_dz;
         a_q  <= in_a;
      end else if (last) begin
         z_q <= zn_q;
         u_q <= diff;
         y_q <= yn_q;
      end
   end

   generate
      if (SHARED_MUL) begin : g_shared
         logic signed [W-1:0] ma, mb, mp;
         diffeq_qmul #(.W(W), .F(F)) u_mul (.op_a(ma), .op_b(mb), .prod(mp));

         always_comb begin
            unique case (step)
               STEP_W'(0): begin ma = THREE; mb = z_q;  end
               STEP_W'(1): begin ma = THREE; mb = y_q;  end
               STEP_W'(2): begin ma = u_q;   mb = dz_q; end
               STEP_W'(3): begin ma = m1_q;  mb = u_q;  end
               STEP_W'(4): begin ma = m2_q;  mb = dz_q; end
               default:    begin ma = m4_q;  mb = dz_q; end
            endcase
            add_a = (step == STEP_W'(0)) ? z_q  : y_q;
            add_b = (step == STEP_W'(0)) ? dz_q : m3_q;
            sub_a = (step == STEP_W'(5)) ? u_q  : s1_q;
            sub_b = (step == STEP_W'(5)) ? m5_q : m6_q;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               m1_q <= '0; m2_q <= '0; m3_q <= '0;
               m4_q <= '0; m5_q <= '0; m6_q <= '0;
               zn_q <= '0; yn_q <= '0; s1_q <= '0;
            end else if (run) begin
               unique case (step)
                  STEP_W'(0): begin m1_q <= mp; zn_q <= sum; end
                  STEP_W'(1): m2_q <= mp;
                  STEP_W'(2): m3_q <= mp;
                  STEP_W'(3): begin m4_q <= mp; yn_q <= sum; end
                  STEP_W'(4): m5_q <= mp;
                  STEP_W'(5): begin m6_q <= mp; s1_q <= diff; end
                  default: ;
               endcase
            end
         end
      end else begin : g_parallel
         logic signed [W-1:0] pa_a, pa_b, pa_p, pb_a, pb_b, pb_p, pc_p;
         diffeq_qmul #(.W(W), .F(F)) u_mul_a (.op_a(pa_a), .op_b(pa_b), .prod(pa_p));
         diffeq_qmul #(.W(W), .F(F)) u_mul_b (.op_a(pb_a), .op_b(pb_b), .prod(pb_p));
         diffeq_qmul #(.W(W), .F(F)) u_mul_c (.op_a(u_q),  .op_b(dz_q), .prod(pc_p));

         always_comb begin
            unique case (step)
               STEP_W'(0): begin pa_a = THREE; pa_b = z_q;  end
               STEP_W'(1): begin pa_a = m1_q;  pa_b = u_q;  end
               default:    begin pa_a = m4_q;  pa_b = dz_q; end
            endcase
            pb_a  = (step == STEP_W'(0)) ? THREE : m2_q;
            pb_b  = (step == STEP_W'(0)) ? y_q   : dz_q;
            add_a = (step == STEP_W'(0)) ? z_q   : y_q;
            add_b = (step == STEP_W'(0)) ? dz_q  : m3_q;
            sub_a = (step == STEP_W'(2)) ? u_q   : s1_q;
            sub_b = (step == STEP_W'(2)) ? m5_q  : m6_q;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               m1_q <= '0; m2_q <= '0; m3_q <= '0;
               m4_q <= '0; m5_q <= '0; m6_q <= '0;
               zn_q <= '0; yn_q <= '0; s1_q <= '0;
            end else if (run) begin
               unique case (step)
                  STEP_W'(0): begin
                     m1_q <= pa_p; m2_q <= pb_p; m3_q <= pc_p; zn_q <= sum;
                  end
                  STEP_W'(1): begin m4_q <= pa_p; m5_q <= pb_p; yn_q <= sum; end
                  STEP_W'(2): begin m6_q <= pa_p; s1_q <= diff; end
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign out_z = z_q;
   assign out_u = u_q;
   assign out_y = y_q;

   p_exit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((chk || last) && !lt) |=> !(z_q < a_q));
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk || run) |=> ($stable(a_q) && $stable(dz_q)));
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || chk || run) |=> ($stable(z_q) && $stable(u_q) && $stable(y_q)));
   p_early_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk |=> ($stable(z_q) && $stable(u_q) && $stable(y_q)));
endmodule

// File: rtl/diffeq_solver.sv
module diffeq_solver #(
   parameter int W          = 16,
   parameter int F          = 8,
   parameter bit SHARED_MUL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] init_z,
   input  logic signed [W-1:0] init_u,
   input  logic signed [W-1:0] init_y,
   input  logic signed [W-1:0] step_dz,
   input  logic signed [W-1:0] bound_a,
   output logic signed [W-1:0] res_z,
   output logic signed [W-1:0] res_u,
   output logic signed [W-1:0] res_y,
   output logic                busy,
   output logic                done
);
   localparam int STEPS  = diffeq_pkg::steps_for(SHARED_MUL);
   localparam int STEP_W = $clog2(STEPS);

   generate
      if (F < 1 || W < F + 3) begin : g_bad_fmt
         $error("diffeq_solver: W must hold the constant 3 above F fraction bits");
      end
   endgenerate

   logic lt, load, chk, run, last;
   logic [STEP_W-1:0] step;

   diffeq_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .lt(lt),
      .busy(busy), .done(done), .load(load), .chk(chk),
      .run(run), .last(last), .step(step)
   );

   diffeq_datapath #(.W(W), .F(F), .SHARED_MUL(SHARED_MUL), .STEP_W(STEP_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .chk(chk), .run(run),
      .last(last), .step(step),
      .in_z(init_z), .in_u(init_u), .in_y(init_y), .in_dz(step_dz), .in_a(bound_a),
      .lt(lt), .out_z(res_z), .out_u(res_u), .out_y(res_y)
   );
endmodule

// File: tb/diffeq_solver_bench.sv
module diffeq_solver_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_p = 1'b0, st_s = 1'b0;
   logic signed [15:0] iz = '0, iu = '0, iy = '0, idz = '0, ia = '0;
   logic signed [15:0] pz, pu, py, sz, su, sy;
   logic pbusy, pdone, sbusy, sdone;
   int checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;

   diffeq_solver #(.SHARED_MUL(1'b0)) u_diffeq_solver (
      .clk(clk), .rst_n(rst_n), .start(st_p), .init_z(iz), .init_u(iu),
      .init_y(iy), .step_dz(idz), .bound_a(ia), .res_z(pz), .res_u(pu),
      .res_y(py), .busy(pbusy), .done(pdone));

   diffeq_solver #(.SHARED_MUL(1'b1)) u_diffeq_solver_shared (
      .clk(clk), .rst_n(rst_n), .start(st_s), .init_z(iz), .init_u(iu),
      .init_y(iy), .step_dz(idz), .bound_a(ia), .res_z(sz), .res_u(su),
      .res_y(sy), .busy(sbusy), .done(sdone));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic signed [15:0] qm(input logic signed [15:0] a,
                                             input logic signed [15:0] b);
      logic signed [31:0] f;
      f = 32'(a) * 32'(b);
      return f[23:8];
   endfunction

   // R3/R4 reference loop
   task automatic model(input logic signed [15:0] z0, u0, y0, dz, a,
                        output logic signed [15:0] z, u, y, output int n);
      logic signed [15:0] zn, un, yn;
      z = z0; u = u0; y = y0; n = 0;
      while (z < a && n < 4000) begin
         zn = z + dz;
         yn = y + qm(u, dz);
         un = u - qm(qm(16'sh0300, y), dz) - qm(qm(qm(16'sh0300, z), u), dz);
         z = zn; u = un; y = yn; n++;
      end
   endtask

   task automatic run(input bit shared, input logic signed [15:0] z0, u0, y0, dz, a,
                      input bit inject);
      logic signed [15:0] ez, eu, ey;
      int n, cnt, steps;
      logic b, d;
      logic signed [15:0] oz, ou, oy;
      steps = shared ? 7 : 4;
      model(z0, u0, y0, dz, a, ez, eu, ey, n);
      @(negedge clk);
      iz = z0; iu = u0; iy = y0; idz = dz; ia = a;
      if (shared) st_s = 1'b1; else st_p = 1'b1;
      @(negedge clk);
      st_s = 1'b0; st_p = 1'b0;
      cnt = 0;
      b = shared ? sbusy : pbusy;
      check("R2 busy after start", int'(b), 1);
      d = shared ? sdone : pdone;
      while (!d && cnt < 5000) begin
         if (inject && cnt == 1) begin
            iz = 16'sh8000; iu = 16'sh1234; iy = -16'sh0777; idz = 16'sh0001; ia = 16'sh7fff;
            if (shared) st_s = 1'b1; else st_p = 1'b1;
         end else begin
            st_s = 1'b0; st_p = 1'b0;
         end
         @(negedge clk);
         cnt++;
         d = shared ? sdone : pdone;
      end
      st_s = 1'b0; st_p = 1'b0;
      oz = shared ? sz : pz; ou = shared ? su : pu; oy = shared ? sy : py;
      b = shared ? sbusy : pbusy;
      if (n == 0) begin
         check("R7 early exit cycles", cnt, 1);
         check("R7 z kept", int'(oz), int'(z0));
         check("R7 u kept", int'(ou), int'(u0));
         check("R7 y kept", int'(oy), int'(y0));
      end else if (shared) begin
         check("R6 shared cycles", cnt, 1 + steps * n);
      end else begin
         check("R5 parallel cycles", cnt, 1 + steps * n);
      end
      if (inject) check("R9 start ignored cycles", cnt, 1 + steps * n);
      check("R3 z", int'(oz), int'(ez));
      check("R3 u", int'(ou), int'(eu));
      check(inject ? "R9 y unaffected" : "R3 y", int'(oy), int'(ey));
      check("R4 z not below bound", int'(!(oz < a)), 1);
      check("R8 busy low with done", int'(b), 0);
      @(negedge clk);
      d = shared ? sdone : pdone;
      check("R8 done single pulse", int'(d), 0);
      repeat (3) @(negedge clk);
      check("R10 z held", int'(shared ? sz : pz), int'(ez));
      check("R10 u held", int'(shared ? su : pu), int'(eu));
      check("R10 y held", int'(shared ? sy : py), int'(ey));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 busy in reset", int'(pbusy | sbusy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", int'(pdone | sdone), 0);
      check("R1 busy after reset", int'(pbusy | sbusy), 0);
      check("R1 results zero", int'(pz | pu | py | sz | su | sy), 0);
      for (int m = 0; m < 2; m++) begin
         run(m[0], 16'sh0200, 16'sh0100, 16'sh0080, 16'sh0020, 16'sh0200, 1'b0); // z0 == a
         run(m[0], 16'sh0300, -16'sh0100, 16'sh0080, 16'sh0020, 16'sh0100, 1'b0); // z0 > a
         run(m[0], 16'sh0000, 16'sh0100, 16'sh0100, 16'sh0040, 16'sh0040, 1'b0); // one pass
         run(m[0], -16'sh0180, -16'sh0133, 16'sh00c5, 16'sh0019, 16'sh0100, 1'b0);
         run(m[0], 16'sh0000, 16'sh0000, 16'sh0100, 16'sh0010, 16'sh0300, 1'b1); // R9
         for (int k = 0; k < 25; k++) begin
            logic signed [15:0] z0, u0, y0, dz, a;
            z0 = 16'($signed($urandom_range(0, 2048)) - 1024);
            u0 = 16'($signed($urandom_range(0, 1024)) - 512);
            y0 = 16'($signed($urandom_range(0, 1024)) - 512);
            dz = 16'($urandom_range(16, 128));
            a  = z0 + 16'($urandom_range(0, 2048));
            run(m[0], z0, u0, y0, dz, a, (k % 5) == 0);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule